// File: doc/BRIEF.md
# Logic Analyzer Sample Strobe Selector

This block decides when a logic-analyzer capture engine takes a sample. It does not switch or gate any physical clock. It produces a single-cycle strobe, `sample_en`, in the analyzer's system clock domain, and the capture engine qualifies its data register with that strobe.

The block has two modes. In timing mode the strobe comes from a programmable divider that runs on the system clock. In state mode, one of the probe lines is chosen at run time to act as the state clock. That line passes through a two-flop synchronizer, and the strobe fires on its rising or falling edge, whichever is selected. The chosen line keeps being captured as data by the rest of the analyzer.

When the mode or the channel index changes, the divider and the edge history start again, so a reconfiguration never produces a spurious sample. While the block is disabled, no strobe is produced.

Top module: `probe_strobe_gen`

## Requirements
- R1: While `enable` is low, `sample_en` stays low. A low `enable` seen at a clock edge forces `sample_en` low after that edge.
- R2: Timing mode (`state_mode`=0) with divider value N. Let E be the first edge at which `enable` is high and the mode and channel index equal their values at the previous edge. The strobe is high for one cycle after edge E+N, and after every (N+1)-th edge from then on. Boundary values are N=1 (half rate) and N=255.
- R3: In timing mode, N=0 makes `sample_en` high after every edge that meets the condition of R2.
- R4: State mode with `edge_fall`=0. A 0-to-1 change on the selected probe line gives `sample_en` high for exactly one cycle. The strobe is set by the third clock edge that samples the new level.
- R5: State mode with `edge_fall`=1. A 1-to-0 change on the selected line gives the same single strobe, with the same three-edge latency as R4.
- R6: Level changes on probe lines other than the one selected by `chan_sel` never produce a strobe.
- R7: A change of `chan_sel` never produces a strobe. This holds even when the newly selected line sits at a different level from the old one. Edges on the new line are honored from the third edge after the change.
- R8: A change of `state_mode` restarts the divider. On return to timing mode, the first strobe follows the rule of R2 and takes no account of any count reached earlier.
- R9: During reset (`rst_n` low), `sample_en` is low.
- R10: A change on the selected line in the direction opposite to the one `edge_fall` selects produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (the 100 MHz analyzer base clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows strobes when high |
| state_mode | input | 1 | 0: timing mode using the divider; 1: state mode using a probe line |
| div_n | input | DIV_W | Divider value N; the strobe period is N+1 clocks |
| chan_sel | input | SEL_W | Index of the probe line used as the state clock |
| edge_fall | input | 1 | 0: rising edge is active; 1: falling edge is active |
| probe | input | CHANNELS | Raw asynchronous probe bus |
| sample_en | output | 1 | Single-cycle sample strobe for the capture engine |

## Verification
The assertions assume that `enable`, `state_mode`, `chan_sel`, `div_n` and `edge_fall` are synchronous to `clk`. They also assume that the polarity selection is not switched in the cycle right after a strobe.

The stimulus changes every input half a period away from the active edge. It configures mode, channel and polarity while the block is disabled, and it waits out the two-edge settling window before it expects any state-mode strobe. Each probe level is held for several cycles, so every transition passes cleanly through the synchronizer.

// File: rtl/probe_strobe_gen.sv
module probe_strobe_gen #(
  parameter int CHANNELS = 16,
  parameter int DIV_W    = 8,
  localparam int SEL_W   = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                state_mode,
  input  logic [DIV_W-1:0]    div_n,
  input  logic [SEL_W-1:0]    chan_sel,
  input  logic                edge_fall,
  input  logic [CHANNELS-1:0] probe,
  output logic                sample_en
);

  logic [2:0]       sync_q;
  logic             mode_q;
  logic [SEL_W-1:0] chan_q;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       arm;
  logic             strobe_q;

  wire cfg_chg  = (state_mode != mode_q) || (chan_sel != chan_q);
  wire clear    = !enable || cfg_chg;
  wire div_hit  = cnt >= div_n;
  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire armed    = arm == 2'd2;
  wire tick     = !state_mode && div_hit;
  wire edge_hit = state_mode && armed && (edge_fall ? fall : rise);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '0;
      mode_q   <= 1'b0;
      chan_q   <= '0;
      cnt      <= '0;
      arm      <= '0;
      strobe_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[1:0], probe[chan_sel]};
      mode_q   <= state_mode;
      chan_q   <= chan_sel;
      cnt      <= (clear || state_mode || div_hit) ? '0 : cnt + 1'b1;
      arm      <= clear ? 2'd0 : (armed ? arm : arm + 2'd1);
      strobe_q <= !clear && (tick || edge_hit);
    end
  end

  assign sample_en = strobe_q;

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sample_en); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !state_mode && $stable(div_n) && cnt != '0) |-> cnt <= div_n); // R2

  AST_DIV0_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !state_mode && div_n == '0 && state_mode == mode_q && chan_sel == chan_q)
      |=> sample_en); // R3

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_mode && sample_en) |=> (!sample_en || !$stable(edge_fall))); // R4

  AST_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_sel != chan_q) |=> !sample_en); // R7

  AST_MODE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_mode != mode_q) |=> (cnt == '0 && !sample_en)); // R8

endmodule

// File: tb/test_probe_strobe_gen.sv
module test_probe_strobe_gen;
  localparam int PERIOD = 10;
  localparam int CH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic state_mode = 1'b0;
  logic [7:0] div_n = '0;
  logic [3:0] chan_sel = '0;
  logic edge_fall = 1'b0;
  logic [CH-1:0] probe = '0;
  logic sample_en;

  probe_strobe_gen i_probe_strobe_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .state_mode(state_mode),
    .div_n(div_n), .chan_sel(chan_sel), .edge_fall(edge_fall),
    .probe(probe), .sample_en(sample_en)
  );

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  string phase = "R9";
  bit done = 0;

  // monitor: one comparison per clock, away from the edge
  always @(posedge clk) begin
    bit want;
    string tg;
    #3;
    cyc++;
    want = 0;
    tg = phase;
    if (exp_q.size() > 0 && exp_q[0] == cyc) begin
      want = 1;
      tg = tag_q[0];
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    n_chk++;
    if (sample_en !== want) begin
      n_bad++;
      $display("FAIL %s cycle %0d: sample_en=%b expected %b", tg, cyc, sample_en, want);
    end
  end

  task automatic push(int c, string tg);
    exp_q.push_back(c);
    tag_q.push_back(tg);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_timing(int n, int count, string tg);
    int k;
    phase = tg;
    enable = 0; state_mode = 0; div_n = n[7:0];
    wait_cyc(2);
    enable = 1;
    k = cyc + 1;
    for (int j = 0; j < count; j++) push(k + n + j * (n + 1), tg);
    wait_cyc((count - 1) * (n + 1) + n + 1);
    enable = 0;
    wait_cyc(3);
  endtask

  task automatic setup_state(int ch, bit fall, string tg);
    phase = tg;
    enable = 0; state_mode = 1; chan_sel = ch[3:0]; edge_fall = fall;
    wait_cyc(2);
    enable = 1;
    wait_cyc(5);
  endtask

  task automatic set_line(int ch, bit lvl, bit expect_strobe, string tg);
    phase = tg;
    probe[ch] = lvl;
    if (expect_strobe) push(cyc + 3, tg);
    wait_cyc(6);
  endtask

  initial begin
    // R9: reset
    wait_cyc(5);
    rst_n = 1;
    wait_cyc(2);

    // R1: disabled with settings that would strobe every cycle
    phase = "R1";
    div_n = 0;
    probe = 16'hFFFF;
    wait_cyc(4);
    probe = 16'h0000;
    wait_cyc(10);

    // R3 then R2 with several divider values
    run_timing(0, 6, "R3");
    run_timing(3, 5, "R2");
    run_timing(1, 6, "R2");
    run_timing(255, 2, "R2");

    // R8: mode switch mid-count restarts the divider
    begin
      int m;
      phase = "R8";
      enable = 0; state_mode = 0; div_n = 5; chan_sel = 0; probe = '0;
      wait_cyc(2);
      enable = 1;
      wait_cyc(2);
      state_mode = 1;
      wait_cyc(4);
      state_mode = 0;
      m = cyc;
      push(m + 7, "R8");
      push(m + 13, "R8");
      wait_cyc(13);
      enable = 0;
      wait_cyc(3);
    end

    // R4 / R10: rising edge active on channel 8
    probe = '0;
    setup_state(8, 0, "R4");
    set_line(8, 1, 1, "R4");
    set_line(8, 0, 0, "R10");
    set_line(8, 1, 1, "R4");
    set_line(8, 0, 0, "R10");

    // R6: other channels toggle, channel 8 held
    phase = "R6";
    probe = probe ^ 16'hFEFF;
    wait_cyc(6);
    probe = probe ^ 16'hFEFF;
    wait_cyc(6);
    set_line(0, 1, 0, "R6");
    set_line(15, 1, 0, "R6");
    enable = 0;
    wait_cyc(2);

    // R5 / R10: falling edge active on channel 2
    probe = 16'h0004;
    setup_state(2, 1, "R5");
    set_line(2, 0, 1, "R5");
    set_line(2, 1, 0, "R10");
    set_line(2, 0, 1, "R5");
    enable = 0;
    wait_cyc(2);

    // R7: switch from a low line to a high line, rising edge active
    probe = 16'h0008;
    setup_state(5, 0, "R7");
    phase = "R7";
    chan_sel = 3;
    wait_cyc(8);
    chan_sel = 5;
    wait_cyc(8);
    chan_sel = 3;
    wait_cyc(8);
    set_line(3, 0, 0, "R7");
    set_line(3, 1, 1, "R7");
    enable = 0;
    wait_cyc(4);

    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL %s: %0d strobes never seen, expected 0 left", tag_q[0], exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule